// File: doc/BRIEF.md
# Sign-Error Adaptive Transversal Filter

This block is a fixed-point adaptive FIR filter meant for noise cancellation. Each time the valid strobe is high it accepts one signed reference sample `x_in` and one desired sample `d_in`. It computes the filter output from the current tap weights over the newest sample and the stored history. From that output it computes the error, and it returns both, registered, one cycle later. Samples and weights are signed two's-complement words of `DW` bits with `DW-1` fractional bits, so full scale is just under ±1.0.

The weights adapt with the sign-error rule. Each tap moves by the tap's history sample, scaled by a power-of-two step, in the direction that the polarity of the last registered error gives. The magnitude of the error plays no part. The step is picked by a 4-bit shift code. The filter sum and every weight increment are rounded to the nearest step, with ties rounded away from zero. Sums that leave the word range are clamped to the nearest extreme value and never wrap. The update on a strobe uses the error registered at the previous strobe together with the history as it stood before this strobe. This gives a one-sample adaptation delay.

Top module: `sgn_lms_fir`

## Requirements
- R1: After reset, `y_out`, `e_out`, `out_vld` and every weight in `w_out` are zero, and the sample history is zero. The first outputs therefore see zero-padded history.
- R2: On a strobe, the filter sum is S = Σ w_k·X_k. Here X_0 is `x_in`, X_k is the sample that arrived k strobes earlier, and w_k are the weights held before the strobe. The sum is divided by 2^(DW-1), rounded to nearest with ties away from zero, and clamped. The result is `y_out` in the next cycle.
- R3: `e_out` = clamp(`d_in` − y), with `d_in` taken from the strobe cycle. It is registered together with `y_out`. `out_vld` is high in exactly the cycles that follow a strobe cycle.
- R4: On a strobe, with s = sign(`e_out` as held at that strobe) ∈ {+1, −1, 0}, each weight becomes w_k ← clamp(w_k + s·round(h_k / 2^n)). Here h_k is the sample that arrived k+1 strobes before the current one, and n is `mu_sh`. Weight k sits in `w_out[k*DW +: DW]`.
- R5: When the held error is exactly zero, a strobe leaves every weight unchanged.
- R6: The weight increment is rounded to nearest with ties away from zero, symmetric for negative values. For example, h=3 with n=1 gives 2, and h=−3 gives −2. A shift code of 0 applies the full sample with no shift.
- R7: A weight sum above 2^(DW-1)−1 is clamped to that value. A weight sum below −2^(DW-1) is clamped to −2^(DW-1).
- R8: The output and the error are clamped in the same way as the weights. For DW=16 they saturate at 32767 and −32768.
- R9: Without a strobe, the weights, the history, `y_out` and `e_out` hold, and `out_vld` is low.
- R10: Driven by white input and a desired signal produced by a fixed FIR plant of the same length, the weights settle near the plant taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Sample strobe |
| x_in | input | DW | Reference sample, signed |
| d_in | input | DW | Desired sample, signed |
| mu_sh | input | 4 | Step shift code n, step = 2^-n |
| out_vld | output | 1 | `y_out` and `e_out` are new |
| y_out | output | DW | Filter output, signed |
| e_out | output | DW | Error d − y, signed |
| w_out | output | TAPS*DW | Tap weights, tap k at bits k*DW |

## Verification
The bench targets the points where a fixed-point LMS filter usually goes wrong.
- Half-step increments of both signs test rounding. A truncating design would leave a 3/2 step at 1, and a non-symmetric one would return −1 for −3/2.
- Full-scale samples at unit step push a weight and the output past the top of the range, and a large negative desired value pushes the error past the bottom. A wrapping design would flip sign there instead of pinning at 32767 or −32768.
- A stream with zero error, and idle cycles with changing inputs, test that nothing moves when it must not. Every strobe is compared against a behavioural model, which exposes an update that uses the current error instead of the held one.
- A long plant-identification run tests that the sign of the update is the right way round.

// File: rtl/sgn_lms_fir.sv
module sgn_lms_fir #(
  parameter int TAPS = 4,
  parameter int DW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] x_in,
  input  logic signed [DW-1:0] d_in,
  input  logic [3:0]           mu_sh,
  output logic                 out_vld,
  output logic signed [DW-1:0] y_out,
  output logic signed [DW-1:0] e_out,
  output logic [TAPS*DW-1:0]   w_out
);
  localparam int FB = DW - 1;
  localparam int AW = 2 * DW + $clog2(TAPS) + 1;
  localparam logic signed [AW-1:0] HI = $signed({{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [AW-1:0] LO = -HI - AW'(1);

  function automatic logic signed [DW-1:0] clamp(input logic signed [AW-1:0] v);
    if (v > HI) return HI[DW-1:0];
    if (v < LO) return LO[DW-1:0];
    return v[DW-1:0];
  endfunction

  function automatic logic signed [AW-1:0] rnd_sh(input logic signed [AW-1:0] v, input logic [4:0] n);
    logic [AW-1:0] m, half;
    half = (AW'(1) << n) >> 1;
    m    = v[AW-1] ? AW'(-v) : AW'(v);
    m    = (m + half) >> n;
    return v[AW-1] ? -$signed(m) : $signed(m);
  endfunction

  function automatic logic signed [AW-1:0] absd(input logic signed [AW-1:0] a, input logic signed [AW-1:0] b);
    return (a > b) ? a - b : b - a;
  endfunction

  logic signed [DW-1:0] hist [TAPS];
  logic signed [DW-1:0] w    [TAPS];
  logic signed [DW-1:0] wn   [TAPS];
  logic signed [DW-1:0] xv   [TAPS];
  logic signed [AW-1:0] acc;
  logic signed [DW-1:0] y_nx, e_nx;
  logic pos, neg;

  assign pos = (e_out > 0);
  assign neg = e_out[DW-1];

  always_comb begin
    xv[0] = x_in;
    for (int k = 1; k < TAPS; k++) xv[k] = hist[k-1];
    acc = '0;
    for (int k = 0; k < TAPS; k++) acc = acc + AW'(w[k]) * AW'(xv[k]);
  end

  assign y_nx = clamp(rnd_sh(acc, 5'(FB)));
  assign e_nx = clamp(AW'(d_in) - AW'(y_nx));

  always_comb begin
    for (int k = 0; k < TAPS; k++) begin
      logic signed [AW-1:0] inc;
      inc   = rnd_sh(AW'(hist[k]), {1'b0, mu_sh});
      wn[k] = (pos || neg) ? clamp(AW'(w[k]) + (neg ? -inc : inc)) : w[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      y_out   <= '0;
      e_out   <= '0;
      for (int k = 0; k < TAPS; k++) begin
        hist[k] <= '0;
        w[k]    <= '0;
      end
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        y_out   <= y_nx;
        e_out   <= e_nx;
        hist[0] <= x_in;
        for (int k = 1; k < TAPS; k++) hist[k] <= hist[k-1];
        for (int k = 0; k < TAPS; k++) w[k] <= wn[k];
      end
    end
  end

  genvar g;
  generate
    for (g = 0; g < TAPS; g++) begin : g_tap
      assign w_out[g*DW +: DW] = w[g];
      // R4
      step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> absd(AW'(w[g]), AW'($past(w[g]))) <= rnd_sh(HI + AW'(1), {1'b0, $past(mu_sh)}));
    end
  endgenerate

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(w_out) && $stable(y_out) && $stable(e_out) && !out_vld));
  // R5
  zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && e_out == '0) |=> $stable(w_out));
  // R3
  err_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> e_out == clamp(AW'($past(d_in)) - AW'(y_out)));
  // R3
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
endmodule

// File: tb/sgn_lms_fir_tb.sv
`timescale 1ns/1ps
module sgn_lms_fir_tb_top;
  localparam int TAPS = 4;
  localparam int DW   = 16;
  localparam longint HI = (64'sd1 <<< (DW-1)) - 1;
  localparam longint LO = -(64'sd1 <<< (DW-1));

  logic clk = 0, rst_n = 0, in_vld = 0;
  logic signed [DW-1:0] x_in = 0, d_in = 0;
  logic [3:0] mu_sh = 0;
  logic out_vld;
  logic signed [DW-1:0] y_out, e_out;
  logic [TAPS*DW-1:0] w_out;

  int checks = 0, errors = 0;
  longint mw[TAPS], mh[TAPS];
  longint my, me;
  bit mv;

  always #2.5 clk = ~clk;

  sgn_lms_fir #(.TAPS(TAPS), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .x_in(x_in), .d_in(d_in),
    .mu_sh(mu_sh), .out_vld(out_vld), .y_out(y_out), .e_out(e_out), .w_out(w_out));

  function automatic longint sat(longint v);
    return v > HI ? HI : (v < LO ? LO : v);
  endfunction

  function automatic longint rnd(longint v, int n);
    longint m;
    if (n == 0) return v;
    m = v < 0 ? -v : v;
    m = (m + (64'sd1 <<< (n-1))) >>> n;
    return v < 0 ? -m : m;
  endfunction

  function automatic longint wt(int k);
    return longint'($signed(w_out[k*DW +: DW]));
  endfunction

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk(out_vld == mv, {tag, " R3 out_vld"}, out_vld, mv);
    chk(y_out == my, {tag, " R2 y_out"}, y_out, my);
    chk(e_out == me, {tag, " R3 e_out"}, e_out, me);
    for (int k = 0; k < TAPS; k++) chk(wt(k) == mw[k], {tag, " R4 weight"}, wt(k), mw[k]);
  endtask

  task automatic strobe(bit v, longint x, longint d, int sh, string tag);
    longint xv[TAPS];
    longint acc, s;
    in_vld = v; x_in = DW'(x); d_in = DW'(d); mu_sh = 4'(sh);
    if (v) begin
      xv[0] = x;
      for (int k = 1; k < TAPS; k++) xv[k] = mh[k-1];
      acc = 0;
      for (int k = 0; k < TAPS; k++) acc += mw[k] * xv[k];
      s = me > 0 ? 1 : (me < 0 ? -1 : 0);
      for (int k = 0; k < TAPS; k++) mw[k] = sat(mw[k] + s * rnd(mh[k], sh));
      for (int k = 0; k < TAPS; k++) mh[k] = xv[k];
      my = sat(rnd(acc, DW-1));
      me = sat(d - my);
      mv = 1;
    end else mv = 0;
    @(posedge clk); @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic do_reset();
    rst_n = 0; in_vld = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int k = 0; k < TAPS; k++) begin mw[k] = 0; mh[k] = 0; end
    my = 0; me = 0; mv = 0;
    @(negedge clk);
    chk(out_vld == 0 && y_out == 0 && e_out == 0 && w_out == '0, "R1 reset state", w_out, 0);
  endtask

  function automatic longint rnd_smp(int lim);
    return longint'($urandom % (2*lim + 1)) - lim;
  endfunction

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint p[TAPS];
    @(negedge clk);
    do_reset();

    // R5: zero desired with zero weights keeps error and weights at zero
    for (int i = 0; i < 8; i++) begin
      strobe(1, rnd_smp(20000), 0, 0, "R5");
      chk(w_out == '0, "R5 weights unchanged", w_out, 0);
    end

    // R6: half-step rounding, both signs
    do_reset();
    strobe(1, 3, 100, 1, "R6");
    strobe(1, 0, -100, 1, "R6");
    chk(wt(0) == 2, "R6 +1.5 rounds to 2", wt(0), 2);
    strobe(1, 0, 0, 1, "R6");
    chk(wt(1) == -2, "R6 -1.5 rounds to -2", wt(1), -2);
    chk(wt(0) == 2, "R6 zero increment", wt(0), 2);

    // R7 / R8: saturation at unit step
    do_reset();
    strobe(1, 30000, 30000, 0, "R7");
    strobe(1, 30000, 30000, 0, "R7");
    chk(wt(0) == 30000, "R6 shift code 0 full step", wt(0), 30000);
    strobe(1, 30000, 30000, 0, "R7");
    chk(wt(0) == 32767, "R7 weight clamp high", wt(0), 32767);
    strobe(1, 30000, -32768, 0, "R8");
    chk(y_out == 32767, "R8 output clamp high", y_out, 32767);
    chk(e_out == -32768, "R8 error clamp low", e_out, -32768);
    for (int i = 0; i < 8; i++) strobe(1, 30000, -32768, 0, "R7 negative");

    // R2 / R4: mixed random traffic with several step codes
    do_reset();
    for (int i = 0; i < 300; i++) strobe(1, rnd_smp(32767), rnd_smp(32767), i % 8, "R2 random");

    // R9: idle cycles with moving inputs
    for (int i = 0; i < 6; i++) strobe(0, rnd_smp(32767), rnd_smp(32767), i, "R9 idle");
    strobe(1, 1234, -4321, 2, "R9 resume");
    for (int i = 0; i < 20; i++) strobe((i % 3) == 0, rnd_smp(32767), rnd_smp(32767), 4, "R9 gaps");

    // R10: plant identification
    do_reset();
    p[0] = 12000; p[1] = -6000; p[2] = 3000; p[3] = 1500;
    for (int i = 0; i < 5000; i++) begin
      longint x, acc;
      x = rnd_smp(16000);
      acc = p[0] * x;
      for (int k = 1; k < TAPS; k++) acc += p[k] * mh[k-1];
      strobe(1, x, sat(rnd(acc, DW-1)), i < 3000 ? 7 : 10, "R10 track");
    end
    for (int k = 0; k < TAPS; k++) begin
      longint dlt;
      dlt = wt(k) - p[k];
      chk(dlt <= 800 && dlt >= -800, "R10 converged tap", wt(k), p[k]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule